// File: doc/BRIEF.md
# DS1 Receive Backplane Serial Interface

This block hands received DS1 frames to local terminal equipment as a serial bitstream at the base 1.544 Mbit/s backplane rate. An upstream framer offers one whole frame at a time over a parallel valid/ready handshake: a framing bit and 24 payload octets. The block shifts that frame out one bit per serial clock. It also drives frame and multiframe markers and a time-slot indication, so the terminal equipment always knows which channel is on the wire.

The serial clock is generated inside the block by dividing the system clock. A configuration input picks the serial clock edge on which data is launched. A second input decides the role of the single-frame sync. In output mode the block marks the last bit of every frame. In input mode the terminal equipment marks the first bit of a frame and the block aligns its bit counter to that mark. Both the resync and underrun conditions are reported as per-frame flags.

Top module: `ds1_rx_backplane`

## Requirements
- R1: `ser_clk` has a period of 2*HALF_DIV system clocks. It rises when its phase counter wraps and stays high for the first HALF_DIV clocks. `ser_data` changes together with a rising `ser_clk` edge when `cfg_clk_inv`=0, and together with a falling edge when `cfg_clk_inv`=1.
- R2: Each frame is 193 bit periods long. It starts with the framing bit and then carries time slots 0 to 23. Slot k is `up_payload[8k+7:8k]`, sent most significant bit first.
- R3: `up_ready` is high for exactly one system clock, in the clock whose edge launches the framing bit of a new frame. The frame on `up_payload`/`up_fbit` is taken when `up_valid` is high in that clock.
- R4: If `up_valid` is low at a frame boundary, all 193 bits of that frame are sent as 1, the framing bit included. `underrun_flag` is 1 for that whole frame and is 0 for frames that were taken.
- R5: With `cfg_sync_in`=0, `sync_out` is high for exactly the bit period of bit 192, the last bit of each frame. With `cfg_sync_in`=1, `sync_out` stays 0.
- R6: `msync_out` is high for the bit period of bit 192 of frame MF_LEN-1 only. The first frame after reset is frame 0, and frames are counted modulo MF_LEN.
- R7: During the framing bit, `ts_fbit`=1 and `ts_num`=0. During payload bit n (1..192), `ts_fbit`=0 and `ts_num`=(n-1)/8. `ts_clk` is high during the framing bit and during the first bit of each slot, and low otherwise.
- R8: With `cfg_sync_in`=1, `sync_in` high at a launch edge makes the launched bit the framing bit of a new frame. Any unsent bits of the old frame are dropped. `resync_flag` is 1 for that new frame when the counter was not already at bit 192. It is 0 for frames that start on the natural boundary.
- R9: While `rst_n` is low, `ser_data`=1 and `ser_clk`=1. `sync_out`, `msync_out`, `ts_clk`, `ts_fbit`, `ts_num`, `resync_flag` and `underrun_flag` are all 0. The first launch after reset sends the framing bit of frame 0.
- R10: With `cfg_sync_in`=0, `sync_in` has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_clk_inv | input | 1 | 0: launch on rising serial clock edge, 1: on falling edge |
| cfg_sync_in | input | 1 | 1: frame sync is an input marking frame start, 0: output marking frame end |
| up_valid | input | 1 | Upstream frame available |
| up_ready | output | 1 | Frame taken this clock if valid |
| up_fbit | input | 1 | Framing bit of the offered frame |
| up_payload | input | 192 | 24 octets, slot k in bits 8k+7..8k |
| sync_in | input | 1 | Frame-start mark from terminal equipment |
| ser_clk | output | 1 | Serial backplane clock |
| ser_data | output | 1 | Serial frame data |
| sync_out | output | 1 | Frame-end mark |
| msync_out | output | 1 | Multiframe-end mark |
| ts_clk | output | 1 | Time-slot indicator clock |
| ts_num | output | 5 | Current time-slot number |
| ts_fbit | output | 1 | Framing-bit period indicator |
| resync_flag | output | 1 | Current frame was started by a misaligned sync mark |
| underrun_flag | output | 1 | Current frame had no upstream data |

## Verification
The assertions assume that upstream data and `up_valid` stay steady through the clock in which `up_ready` is high. They also assume that a frame-start mark on `sync_in` lasts one serial bit period, so that it meets exactly one launch edge. The stimulus changes inputs only away from clock edges and holds each sync mark for exactly 2*HALF_DIV clocks. It changes `cfg_clk_inv` and `cfg_sync_in` between frames. The reference model follows the same rules, so every output can be compared on every clock.

// File: rtl/ds1rx_pkg.sv
package ds1rx_pkg;
  localparam int DS1_SLOTS      = 24;
  localparam int DS1_SLOT_W     = 8;
  localparam int DS1_PAY_W      = DS1_SLOTS * DS1_SLOT_W;
  localparam int DS1_FRAME_BITS = DS1_PAY_W + 1;
  localparam int DS1_POS_W      = $clog2(DS1_FRAME_BITS);
  localparam int DS1_LAST_POS   = DS1_FRAME_BITS - 1;
  localparam int DS1_TS_W       = $clog2(DS1_SLOTS);
endpackage

// File: rtl/ds1rx_clkgen.sv
// Serial clock divider; flags the system clock whose edge is the launch edge.
module ds1rx_clkgen #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_clk_inv,
  output logic ser_clk,
  output logic launch
);
  localparam int PERIOD = 2 * HALF_DIV;
  localparam int PH_W   = $clog2(PERIOD);

  logic [PH_W-1:0] ph_q, ph_d;
  logic            sclk_q, sclk_d;

  always_comb begin
    ph_d   = (ph_q == PH_W'(PERIOD - 1)) ? '0 : ph_q + PH_W'(1);
    sclk_d = (ph_d < PH_W'(HALF_DIV));
    launch = cfg_clk_inv ? (ph_q == PH_W'(HALF_DIV - 1))
                         : (ph_q == PH_W'(PERIOD - 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= '0;
      sclk_q <= 1'b1;
    end else begin
      ph_q   <= ph_d;
      sclk_q <= sclk_d;
    end
  end

  assign ser_clk = sclk_q;

  // R1: a launch strobe never lasts two clocks
  assert_launch_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> !launch);
endmodule

// File: rtl/ds1rx_framecnt.sv
// Bit and frame position, sync handling and time-slot indication.
module ds1rx_framecnt
  import ds1rx_pkg::*;
#(
  parameter int MF_LEN = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 launch,
  input  logic                 cfg_sync_in,
  input  logic                 sync_in,
  output logic                 frame_start,
  output logic [DS1_POS_W-1:0] nxt_pos,
  output logic                 sync_out,
  output logic                 msync_out,
  output logic                 resync_flag,
  output logic [DS1_TS_W-1:0]  ts_num,
  output logic                 ts_fbit,
  output logic                 ts_clk
);
  localparam int FR_W = (MF_LEN > 1) ? $clog2(MF_LEN) : 1;
  localparam logic [DS1_POS_W-1:0] LAST = DS1_POS_W'(DS1_LAST_POS);

  logic [DS1_POS_W-1:0] pos_q, pos_d, nat_pos, j;
  logic [FR_W-1:0]      fr_q, fr_d;
  logic                 force_start;
  logic                 sync_q, sync_d, msync_q, msync_d, res_q, res_d;
  logic                 fb_q, fb_d, tsc_q, tsc_d;
  logic [DS1_TS_W-1:0]  tsn_q, tsn_d;

  always_comb begin
    nat_pos     = (pos_q == LAST) ? '0 : pos_q + DS1_POS_W'(1);
    force_start = cfg_sync_in && sync_in;
    nxt_pos     = force_start ? '0 : nat_pos;
    frame_start = launch && (nxt_pos == '0);
    j           = nxt_pos - DS1_POS_W'(1);
    // hold everything unless this is a launch clock
    pos_d   = pos_q;
    fr_d    = fr_q;
    sync_d  = sync_q;
    msync_d = msync_q;
    res_d   = res_q;
    tsn_d   = tsn_q;
    fb_d    = fb_q;
    tsc_d   = tsc_q;
    if (launch) begin
      pos_d   = nxt_pos;
      sync_d  = !cfg_sync_in && (nxt_pos == LAST);
      msync_d = (nxt_pos == LAST) && (fr_q == FR_W'(MF_LEN - 1));
      fb_d    = (nxt_pos == '0);
      tsn_d   = (nxt_pos == '0) ? '0 : DS1_TS_W'(j[DS1_POS_W-1:3]);
      tsc_d   = (nxt_pos == '0) || (j[2:0] == 3'd0);
      if (frame_start) begin
        fr_d  = (fr_q == FR_W'(MF_LEN - 1)) ? '0 : fr_q + FR_W'(1);
        res_d = force_start && (nat_pos != '0);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q   <= LAST;
      fr_q    <= FR_W'(MF_LEN - 1);
      sync_q  <= 1'b0;
      msync_q <= 1'b0;
      res_q   <= 1'b0;
      tsn_q   <= '0;
      fb_q    <= 1'b0;
      tsc_q   <= 1'b0;
    end else begin
      pos_q   <= pos_d;
      fr_q    <= fr_d;
      sync_q  <= sync_d;
      msync_q <= msync_d;
      res_q   <= res_d;
      tsn_q   <= tsn_d;
      fb_q    <= fb_d;
      tsc_q   <= tsc_d;
    end
  end

  assign sync_out    = sync_q;
  assign msync_out   = msync_q;
  assign resync_flag = res_q;
  assign ts_num      = tsn_q;
  assign ts_fbit     = fb_q;
  assign ts_clk      = tsc_q;

  // R8: a mid-frame start mark realigns to the framing bit and flags it
  assert_resync_realign_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && cfg_sync_in && sync_in && pos_q != LAST) |=> (resync_flag && ts_fbit));
  // R7: slot number stays within 0..23
  assert_ts_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ts_num <= DS1_TS_W'(DS1_SLOTS - 1));
endmodule

// File: rtl/ds1rx_serializer.sv
// Frame holding register, upstream handshake and bit selection.
module ds1rx_serializer
  import ds1rx_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 launch,
  input  logic                 frame_start,
  input  logic [DS1_POS_W-1:0] nxt_pos,
  input  logic                 up_valid,
  input  logic                 up_fbit,
  input  logic [DS1_PAY_W-1:0] up_payload,
  output logic                 up_ready,
  output logic                 ser_data,
  output logic                 underrun_flag
);
  logic [DS1_PAY_W-1:0] pay_q, pay_d;
  logic                 dat_q, dat_d, und_q, und_d, bit_sel;
  logic [DS1_POS_W-1:0] j, bidx;

  always_comb begin
    up_ready = frame_start;
    j        = nxt_pos - DS1_POS_W'(1);
    // slot j/8 occupies bits 8*slot..8*slot+7; MSB leaves first
    bidx     = {j[DS1_POS_W-1:3], ~j[2:0]};
    bit_sel  = (nxt_pos == '0) ? 1'b1 : pay_q[bidx];
    pay_d    = pay_q;
    und_d    = und_q;
    dat_d    = dat_q;
    if (frame_start) begin
      pay_d = up_valid ? up_payload : '1;
      und_d = !up_valid;
      dat_d = up_valid ? up_fbit : 1'b1;
    end else if (launch) begin
      dat_d = bit_sel;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pay_q <= '1;
      dat_q <= 1'b1;
      und_q <= 1'b0;
    end else begin
      pay_q <= pay_d;
      dat_q <= dat_d;
      und_q <= und_d;
    end
  end

  assign ser_data      = dat_q;
  assign underrun_flag = und_q;

  // R4: a boundary without data starts an all-ones frame with the flag up
  assert_underrun_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && !up_valid) |=> (ser_data && underrun_flag));
  // R3: ready is a single-clock pulse
  assert_ready_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    up_ready |=> !up_ready);
endmodule

// File: rtl/ds1_rx_backplane.sv
module ds1_rx_backplane
  import ds1rx_pkg::*;
#(
  parameter int HALF_DIV = 2,
  parameter int MF_LEN   = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_clk_inv,
  input  logic                 cfg_sync_in,
  input  logic                 up_valid,
  output logic                 up_ready,
  input  logic                 up_fbit,
  input  logic [DS1_PAY_W-1:0] up_payload,
  input  logic                 sync_in,
  output logic                 ser_clk,
  output logic                 ser_data,
  output logic                 sync_out,
  output logic                 msync_out,
  output logic                 ts_clk,
  output logic [DS1_TS_W-1:0]  ts_num,
  output logic                 ts_fbit,
  output logic                 resync_flag,
  output logic                 underrun_flag
);
  logic                 launch, frame_start;
  logic [DS1_POS_W-1:0] nxt_pos;

  ds1rx_clkgen #(.HALF_DIV(HALF_DIV)) u_clkgen (
    .clk(clk), .rst_n(rst_n), .cfg_clk_inv(cfg_clk_inv),
    .ser_clk(ser_clk), .launch(launch));

  ds1rx_framecnt #(.MF_LEN(MF_LEN)) u_framecnt (
    .clk(clk), .rst_n(rst_n), .launch(launch), .cfg_sync_in(cfg_sync_in),
    .sync_in(sync_in), .frame_start(frame_start), .nxt_pos(nxt_pos),
    .sync_out(sync_out), .msync_out(msync_out), .resync_flag(resync_flag),
    .ts_num(ts_num), .ts_fbit(ts_fbit), .ts_clk(ts_clk));

  ds1rx_serializer u_serializer (
    .clk(clk), .rst_n(rst_n), .launch(launch), .frame_start(frame_start),
    .nxt_pos(nxt_pos), .up_valid(up_valid), .up_fbit(up_fbit),
    .up_payload(up_payload), .up_ready(up_ready), .ser_data(ser_data),
    .underrun_flag(underrun_flag));

  // R1: data moves only with the selected serial clock edge
  assert_launch_edge_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ser_data) |-> ($past(cfg_clk_inv) ? $fell(ser_clk) : $rose(ser_clk)));
  // R2: a taken frame begins with its framing bit
  assert_load_fbit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    up_ready |=> ts_fbit);
  // R5: the frame-end mark gives way to a framing bit
  assert_sync_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sync_out) |-> ts_fbit);
  // R6: the multiframe mark sits on the last payload bit of slot 23
  assert_msync_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
    msync_out |-> (ts_num == DS1_TS_W'(DS1_SLOTS - 1) && !ts_fbit));
endmodule

// File: tb/ds1_rx_backplane_bench.sv
`timescale 1ns/1ps
module ds1_rx_backplane_bench;
  localparam int HALF = 2;
  localparam int PER  = 2 * HALF;
  localparam int MF   = 12;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0;
  logic cfg_clk_inv = 1'b0, cfg_sync_in = 1'b0, sync_in = 1'b0;
  logic up_valid = 1'b1, up_fbit = 1'b0;
  logic [191:0] up_payload = '0;
  logic up_ready, ser_clk, ser_data, sync_out, msync_out, ts_clk, ts_fbit;
  logic resync_flag, underrun_flag;
  logic [4:0] ts_num;

  ds1_rx_backplane #(.HALF_DIV(HALF), .MF_LEN(MF)) u_ds1_rx_backplane (
    .clk(clk), .rst_n(rst_n), .cfg_clk_inv(cfg_clk_inv), .cfg_sync_in(cfg_sync_in),
    .up_valid(up_valid), .up_ready(up_ready), .up_fbit(up_fbit),
    .up_payload(up_payload), .sync_in(sync_in), .ser_clk(ser_clk),
    .ser_data(ser_data), .sync_out(sync_out), .msync_out(msync_out),
    .ts_clk(ts_clk), .ts_num(ts_num), .ts_fbit(ts_fbit),
    .resync_flag(resync_flag), .underrun_flag(underrun_flag));

  int checks = 0, fails = 0;
  string phase = "R9 reset";

  // behavioural reference state
  int mph, mpos, mfr, nframes = 0;
  bit q[$];
  logic exp_clk, exp_data, exp_sync, exp_msync, exp_res, exp_und;
  logic exp_tsf, exp_tsc;
  int exp_tsn;
  logic rdy_seen = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s (phase %s) actual=%0d expected=%0d", tag, phase, act, expv);
    end
  endtask

  task automatic model_reset();
    mph = 0; mpos = 192; mfr = MF - 1; q.delete();
    exp_clk = 1; exp_data = 1; exp_sync = 0; exp_msync = 0; exp_res = 0;
    exp_und = 0; exp_tsn = 0; exp_tsf = 0; exp_tsc = 0;
  endtask

  task automatic model_step();
    bit ln, forced, boundary;
    int np;
    boundary = 0;
    ln = cfg_clk_inv ? (mph == HALF - 1) : (mph == PER - 1);
    mph = (mph + 1) % PER;
    exp_clk = (mph < HALF);
    if (ln) begin
      np = (mpos == 192) ? 0 : mpos + 1;
      forced = cfg_sync_in && sync_in;
      if (forced) begin
        if (np != 0) q.delete();
        np = 0;
      end
      if (np == 0) begin
        boundary = 1;
        exp_res = forced && (mpos != 192);
        exp_und = !up_valid;
        q.push_back(up_valid ? up_fbit : 1'b1);
        for (int k = 0; k < 24; k++)
          for (int b = 7; b >= 0; b--)
            q.push_back(up_valid ? up_payload[8*k+b] : 1'b1);
        mfr = (mfr + 1) % MF;
        nframes++;
      end
      exp_data  = q.pop_front();
      mpos      = np;
      exp_sync  = !cfg_sync_in && (np == 192);
      exp_msync = (np == 192) && (mfr == MF - 1);
      exp_tsf   = (np == 0);
      exp_tsn   = (np == 0) ? 0 : (np - 1) / 8;
      exp_tsc   = (np == 0) || ((np - 1) % 8 == 0);
    end
    chk(rdy_seen == boundary, "R3 up_ready", rdy_seen, boundary);
  endtask

  initial model_reset();
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) model_reset();
    else model_step();
  end

  // compare every output on every clock, between edges
  always @(negedge clk) begin
    rdy_seen = up_ready;
    chk(ser_clk === exp_clk, "R1 ser_clk", ser_clk, exp_clk);
    chk(ser_data === exp_data, "R2 ser_data", ser_data, exp_data);
    chk(sync_out === exp_sync, "R5 sync_out", sync_out, exp_sync);
    chk(msync_out === exp_msync, "R6 msync_out", msync_out, exp_msync);
    chk(ts_num === 5'(exp_tsn) && ts_fbit === exp_tsf && ts_clk === exp_tsc,
        "R7 ts_num/ts_fbit/ts_clk", {ts_num, ts_fbit, ts_clk}, {exp_tsn[4:0], exp_tsf, exp_tsc});
    chk(underrun_flag === exp_und, "R4 underrun_flag", underrun_flag, exp_und);
    chk(resync_flag === exp_res, "R8 resync_flag", resync_flag, exp_res);
  end

  // payload for the next frame follows the model's frame count
  always @(posedge clk) begin
    #3;
    for (int k = 0; k < 24; k++) up_payload[8*k +: 8] = 8'(nframes * 29 + k * 11 + 5);
    up_fbit = (nframes % 3) != 0;
  end

  task automatic tick();
    @(posedge clk); #3;
  endtask

  task automatic wait_frames(input int n);
    int target;
    target = nframes + n;
    while (nframes < target) tick();
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired (phase %s) actual=running expected=done", phase);
    finish_run();
  end

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk(ser_data === 1'b1 && ser_clk === 1'b1 && sync_out === 1'b0 && msync_out === 1'b0
        && ts_num === 5'd0 && ts_fbit === 1'b0 && resync_flag === 1'b0
        && underrun_flag === 1'b0, "R9 reset state", ser_data, 1);
    @(posedge clk); #3;
    rst_n = 1'b1;
    phase = "R2 R3 R6 R7 normal";
    wait_frames(13);
    phase = "R4 underrun";
    up_valid = 1'b0;
    wait_frames(2);
    up_valid = 1'b1;
    wait_frames(1);
    phase = "R1 falling launch";
    cfg_clk_inv = 1'b1;
    wait_frames(2);
    phase = "R10 sync ignored";
    repeat (30) begin
      repeat (53) tick();
      sync_in = 1'b1;
      repeat (PER) tick();
      sync_in = 1'b0;
    end
    phase = "R8 aligned mark";
    cfg_sync_in = 1'b1;
    wait_frames(1);
    while (mpos != 192) tick();
    sync_in = 1'b1;
    repeat (PER) tick();
    sync_in = 1'b0;
    @(negedge clk);
    chk(resync_flag === 1'b0, "R8 aligned mark leaves flag low", resync_flag, 0);
    tick();
    phase = "R8 misaligned mark";
    while (mpos != 50) tick();
    sync_in = 1'b1;
    repeat (PER) tick();
    sync_in = 1'b0;
    @(negedge clk);
    chk(resync_flag === 1'b1 && ts_fbit === 1'b1, "R8 misaligned mark sets flag",
        resync_flag, 1);
    tick();
    wait_frames(2);
    cfg_clk_inv = 1'b0;
    wait_frames(1);
    finish_run();
  end
endmodule